// File: doc/BRIEF.md
# HDLC Receive Deframer with Frame Check

This block recovers HDLC packets from a serial signalling channel. It takes one line bit per strobe, looks for the flag pattern, removes the zeros the transmitter inserted after runs of five ones, and notices aborts. It accumulates the 16-bit frame check over each frame and keeps the last 16 bits before the closing flag away from the byte output. Each data byte (address, control, information) is presented for one clock with a marker for the first byte of a packet. The last byte carries an end-of-packet marker and a good/bad verdict, which suits a downstream store that keeps two status bits per byte.

The block also keeps the frame check word exactly as it arrived on the line, for software to inspect. A receive enable starts reception at once. Clearing the enable stops reception at a clean packet boundary.

Top module: `hdlc_rx_deframer`

## Requirements
- R1: After reset, and whenever reception is switched on, the block ignores every bit until it sees a flag (0 followed by six 1s and a 0). A packet that is already under way when the enable rises produces no output. After reset all outputs and `rx_fcs` are zero.
- R2: A 0 received right after five consecutive 1s is removed and is not part of the frame content, so data bytes 0xFF and 0x7E come through unchanged.
- R3: Only address, control and information bytes are output. The 16 bits before the closing flag never appear. The first bit received is bit 0 of a byte. `out_first` is set on the first byte of a packet only, and `out_eop` is set on its last byte only.
- R4: The last byte is marked good (`out_good`=1) only when two things hold. First, the frame check over all frame bits, with the check word included, leaves 0xF0B8. The check is the reflected CRC-16 with polynomial 0x8408 and preset 0xFFFF, and the check word is sent as the complement of the register, low bit first. Second, the frame length is a whole number of bytes. Otherwise the end-of-packet byte is marked bad. `out_good` is never set on a byte without `out_eop`.
- R5: A frame with fewer than 32 bits between its flags is never good. A 24-bit frame outputs its single byte with `out_eop`=1 and `out_good`=0. A 16-bit frame outputs nothing.
- R6: Seven consecutive 1s inside a packet end it: the byte still held is output with `out_eop`=1 and `out_good`=0. The block then waits for a new flag before it receives the next packet.
- R7: At each closing flag that ends a frame of at least 16 bits, `rx_fcs` takes the last 16 frame bits as they were sent, with the first of them in bit 15. At no other time does it change.
- R8: Raising `rx_enable` takes effect on the same cycle, so a flag whose first bit is strobed on that cycle is recognised.
- R9: Once the first 40 bits of a frame have arrived, clearing `rx_enable` still lets that packet complete with all its bytes and its verdict. If it is cleared within the first 16 bits, that packet yields no byte. After that, nothing is received until the enable is set again.
- R10: Idle flags, including back-to-back flags, produce no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_enable | input | 1 | Receive enable |
| bit_en | input | 1 | Strobe: `bit_in` carries a line bit this cycle |
| bit_in | input | 1 | Serial line bit |
| out_valid | output | 1 | One-cycle pulse: a data byte is presented |
| out_byte | output | 8 | Data byte, first received bit in bit 0 |
| out_first | output | 1 | Byte is the first of its packet |
| out_eop | output | 1 | Byte is the last of its packet |
| out_good | output | 1 | With `out_eop`: packet passed length and check |
| rx_fcs | output | 16 | Last received check word, first line bit in bit 15 |

## Verification
A wrong count of ones or a wrong hunt/frame state shows at the next flag. Packets are then lost, or extra bytes or check bytes leak out, and the byte count at `out_eop` differs from the sent payload. A fault in the bit window or the check register shows up as a wrong byte value or a wrong verdict within about 24 bit times of the affected bit. In that case `rx_fcs` also disagrees with the sent check word right after the closing flag. Enable faults show as a dropped packet, or as a packet accepted that should have been dropped, within the packet concerned.

// File: rtl/hdlc_rx_pkg.sv
// Shared constants and types of the HDLC receive deframer.
package hdlc_rx_pkg;
    localparam int          BYTE_W       = 8;
    localparam int          FCS_W        = 16;
    localparam logic [15:0] FCS_POLY_REV = 16'h8408;
    localparam logic [15:0] FCS_PRESET   = 16'hFFFF;
    localparam logic [15:0] FCS_RESIDUE  = 16'hF0B8;

    // A byte waiting to be released, with its first-of-packet mark.
    typedef struct packed {
        logic [BYTE_W-1:0] data;
        logic              first;
    } held_byte_t;
endpackage

// File: rtl/hdlc_bit_unstuff.sv
// Classifies each strobed line bit as a data bit, a deleted stuffing zero,
// a flag end or an abort, from a running count of consecutive ones.
// Assumes: one bit per strobe; clr returns the count to zero.
module hdlc_bit_unstuff #(
    parameter int ONE_RUN = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic stb,
    input  logic din,
    output logic dat_stb,
    output logic dat_bit,
    output logic flag_stb,
    output logic abort_stb
);
    localparam int ONE_MAX = ONE_RUN + 2;
    localparam int CNT_W   = $clog2(ONE_MAX + 1);

    logic [CNT_W-1:0] ones;
    logic             at_run;
    logic             at_six;

    // Decode the current bit against the run of ones before it.
    always_comb begin
        at_run    = (ones == CNT_W'(ONE_RUN));
        at_six    = (ones == CNT_W'(ONE_RUN + 1));
        flag_stb  = stb & ~din & at_six;
        abort_stb = stb &  din & at_six;
        dat_stb   = stb & ((ones < CNT_W'(ONE_RUN)) | (at_run & din));
        dat_bit   = din;
    end

    // Track consecutive ones, saturating after an abort.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            ones <= '0;
        end else if (stb) begin
            if (!din)                           ones <= '0;
            else if (ones != CNT_W'(ONE_MAX))   ones <= ones + 1'b1;
        end
    end
endmodule

// File: rtl/hdlc_fcs16.sv
// Bit-serial frame check register, low bit first (reflected form).
// Assumes: init has priority over en.
module hdlc_fcs16 #(
    parameter int          W      = 16,
    parameter logic [W-1:0] POLY   = 16'h8408,
    parameter logic [W-1:0] PRESET = 16'hFFFF
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         init,
    input  logic         en,
    input  logic         din,
    output logic [W-1:0] crc
);
    // Shift one bit into the check register.
    always_ff @(posedge clk) begin
        if (!rst_n || init)  crc <= PRESET;
        else if (en)         crc <= (crc >> 1) ^ ((crc[0] ^ din) ? POLY : '0);
    end
endmodule

// File: rtl/hdlc_frame_ctl.sv
// Frame tracking: holds the newest frame bits in a window so that the flag
// and check bits never leave as data, releases bytes through a one-byte
// hold so that the last byte can carry the verdict, and captures the check
// word. Assumes BYTE_W is a power of two and events are mutually exclusive.
module hdlc_frame_ctl
    import hdlc_rx_pkg::*;
#(
    parameter int FLAG_W   = 8,
    parameter int MIN_BITS = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              dat_stb,
    input  logic              dat_bit,
    input  logic              flag_stb,
    input  logic              abort_stb,
    input  logic              crc_ok,
    output logic              crc_init,
    output logic              crc_en,
    output logic              crc_bit,
    output logic              pend_busy,
    output logic              out_valid,
    output logic [BYTE_W-1:0] out_byte,
    output logic              out_first,
    output logic              out_eop,
    output logic              out_good,
    output logic [FCS_W-1:0]  rx_fcs
);
    localparam int TAIL    = FCS_W + FLAG_W - 1;
    localparam int SR_W    = TAIL + BYTE_W;
    localparam int MIN_N   = MIN_BITS + FLAG_W - 1;
    localparam int CAP     = (MIN_N > SR_W) ? MIN_N : SR_W;
    localparam int CNT_W   = $clog2(CAP + 1);
    localparam int PH_W    = $clog2(BYTE_W);
    localparam int FCS_LO  = SR_W - FLAG_W - FCS_W + 1;
    localparam int CRC_TAP = SR_W - FLAG_W;

    logic [SR_W-1:0]  sr, sr_next;
    logic [CNT_W-1:0] n, n_next;
    logic [PH_W-1:0]  ph, ph_next;
    logic             in_frame, first_due, pend_v;
    held_byte_t       pend;
    logic             dat_go, extract, closing, frame_ok, fcs_cap;
    logic [FCS_W-1:0] fcs_view;

    // Next-state values of the bit window and counters.
    always_comb begin
        sr_next = {dat_bit, sr[SR_W-1:1]};
        n_next  = (n == CNT_W'(CAP)) ? n : n + 1'b1;
        ph_next = ph + 1'b1;
        dat_go  = in_frame & dat_stb;
        extract = dat_go & (ph_next == PH_W'(TAIL % BYTE_W)) & (n_next >= CNT_W'(SR_W));
        closing = in_frame & flag_stb & (n > CNT_W'(FLAG_W - 1));
        frame_ok = (ph == PH_W'((FLAG_W - 1) % BYTE_W)) & (n >= CNT_W'(MIN_N)) & crc_ok;
        fcs_cap = closing & (n >= CNT_W'(TAIL));
    end

    // Check word as sent: earliest line bit to the top.
    always_comb begin
        for (int i = 0; i < FCS_W; i++) fcs_view[FCS_W-1-i] = sr[FCS_LO+i];
    end

    // Feed the check register with bits old enough to be frame bits.
    assign crc_init  = flag_stb;
    assign crc_en    = dat_go & (n_next >= CNT_W'(FLAG_W));
    assign crc_bit   = sr_next[CRC_TAP];
    assign pend_busy = pend_v;

    // Frame state, byte hold and output register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr <= '0; n <= '0; ph <= '0;
            in_frame <= 1'b0; first_due <= 1'b0; pend_v <= 1'b0; pend <= '0;
            out_valid <= 1'b0; out_byte <= '0; out_first <= 1'b0;
            out_eop <= 1'b0; out_good <= 1'b0; rx_fcs <= '0;
        end else if (clr) begin
            n <= '0; ph <= '0;
            in_frame <= 1'b0; pend_v <= 1'b0; out_valid <= 1'b0;
        end else begin
            out_valid <= 1'b0;
            if (flag_stb) begin
                if (closing && pend_v) begin
                    out_valid <= 1'b1; out_byte <= pend.data; out_first <= pend.first;
                    out_eop <= 1'b1; out_good <= frame_ok;
                end
                if (fcs_cap) rx_fcs <= fcs_view;
                pend_v <= 1'b0; in_frame <= 1'b1; first_due <= 1'b1;
                n <= '0; ph <= '0;
            end else if (abort_stb) begin
                if (in_frame && pend_v) begin
                    out_valid <= 1'b1; out_byte <= pend.data; out_first <= pend.first;
                    out_eop <= 1'b1; out_good <= 1'b0;
                end
                pend_v <= 1'b0; in_frame <= 1'b0;
            end else if (dat_go) begin
                sr <= sr_next; n <= n_next; ph <= ph_next;
                if (extract) begin
                    if (pend_v) begin
                        out_valid <= 1'b1; out_byte <= pend.data; out_first <= pend.first;
                        out_eop <= 1'b0; out_good <= 1'b0;
                    end
                    pend.data  <= sr_next[BYTE_W-1:0];
                    pend.first <= first_due;
                    pend_v     <= 1'b1;
                    first_due  <= 1'b0;
                end
            end
        end
    end

    AST_GOOD_ONLY_AT_EOP: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_good) |-> out_eop); // R4
    AST_GOOD_NOT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_eop && out_good) |-> !out_first); // R5
    AST_OUT_NEEDS_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_frame)); // R1
endmodule

// File: rtl/hdlc_rx_deframer.sv
// Top of the HDLC receive deframer: enable policy, bit classification,
// frame check and frame tracking. Assumes bit_en marks one line bit per
// cycle at most; outputs are registered one-cycle byte events.
module hdlc_rx_deframer
    import hdlc_rx_pkg::*;
#(
    parameter int ONE_RUN  = 5,
    parameter int MIN_BITS = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_enable,
    input  logic              bit_en,
    input  logic              bit_in,
    output logic              out_valid,
    output logic [BYTE_W-1:0] out_byte,
    output logic              out_first,
    output logic              out_eop,
    output logic              out_good,
    output logic [FCS_W-1:0]  rx_fcs
);
    localparam int FLAG_W = ONE_RUN + 3;

    logic             keep_q, active, stb;
    logic             dat_stb, dat_bit, flag_stb, abort_stb;
    logic             crc_init, crc_en, crc_bit, pend_busy;
    logic [FCS_W-1:0] crc;

    // Receiver runs while enabled, or while draining a started packet.
    always_comb begin
        active = rx_enable | (keep_q & pend_busy);
        stb    = bit_en & active;
    end

    // Remember whether the receiver ran last cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) keep_q <= 1'b0;
        else        keep_q <= active;
    end

    hdlc_bit_unstuff #(.ONE_RUN(ONE_RUN)) unstuff_i (
        .clk(clk), .rst_n(rst_n), .clr(~active), .stb(stb), .din(bit_in),
        .dat_stb(dat_stb), .dat_bit(dat_bit), .flag_stb(flag_stb), .abort_stb(abort_stb)
    );

    hdlc_fcs16 #(.W(FCS_W), .POLY(FCS_POLY_REV), .PRESET(FCS_PRESET)) fcs_i (
        .clk(clk), .rst_n(rst_n), .init(crc_init), .en(crc_en), .din(crc_bit), .crc(crc)
    );

    hdlc_frame_ctl #(.FLAG_W(FLAG_W), .MIN_BITS(MIN_BITS)) frame_i (
        .clk(clk), .rst_n(rst_n), .clr(~active),
        .dat_stb(dat_stb), .dat_bit(dat_bit), .flag_stb(flag_stb), .abort_stb(abort_stb),
        .crc_ok(crc == FCS_RESIDUE),
        .crc_init(crc_init), .crc_en(crc_en), .crc_bit(crc_bit), .pend_busy(pend_busy),
        .out_valid(out_valid), .out_byte(out_byte), .out_first(out_first),
        .out_eop(out_eop), .out_good(out_good), .rx_fcs(rx_fcs)
    );

    AST_FCS_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !flag_stb |=> $stable(rx_fcs)); // R7
    AST_OUT_WHILE_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(active)); // R9
endmodule

// File: tb/hdlc_rx_deframer_tb.sv
`timescale 1ns/1ps
module hdlc_rx_deframer_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_enable = 1'b0;
    logic        bit_en = 1'b0;
    logic        bit_in = 1'b0;
    logic        out_valid, out_first, out_eop, out_good;
    logic [7:0]  out_byte;
    logic [15:0] rx_fcs;

    int total = 0;
    int bad   = 0;

    always #2.5 clk = ~clk;

    hdlc_rx_deframer dut_i (
        .clk(clk), .rst_n(rst_n), .rx_enable(rx_enable), .bit_en(bit_en), .bit_in(bit_in),
        .out_valid(out_valid), .out_byte(out_byte), .out_first(out_first),
        .out_eop(out_eop), .out_good(out_good), .rx_fcs(rx_fcs)
    );

    // Output capture, sampled away from the active edge.
    logic [7:0] cap_b [256];
    logic       cap_f [256];
    logic       cap_e [256];
    logic       cap_g [256];
    int         cap_n = 0;
    always @(negedge clk) begin
        if (rst_n && out_valid && cap_n < 256) begin
            cap_b[cap_n] = out_byte; cap_f[cap_n] = out_first;
            cap_e[cap_n] = out_eop;  cap_g[cap_n] = out_good;
            cap_n = cap_n + 1;
        end
    end

    // Stimulus vectors: payload (byte 0 lowest), length, corrupted check.
    localparam int NV = 7;
    localparam logic [63:0] V_DATA [NV] = '{64'h0103, 64'hF07EFF, 64'h78563412,
                                            64'h55, 64'hC3813FFFFF00, 64'hFFFF, 64'h0};
    localparam int V_LEN [NV] = '{2, 3, 4, 1, 6, 2, 0};
    localparam bit V_BAD [NV] = '{1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0};

    logic [15:0] g_crc;
    int          st_ones;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick(input logic b, input logic en);
        @(negedge clk);
        bit_in = b;
        bit_en = en;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) tick(1'b0, 1'b0);
    endtask

    task automatic send_flag();
        tick(1'b0, 1'b1);
        for (int i = 0; i < 6; i++) tick(1'b1, 1'b1);
        tick(1'b0, 1'b1);
        st_ones = 0;
    endtask

    task automatic send_dbit(input logic b);
        tick(b, 1'b1);
        if (b) begin
            st_ones++;
            if (st_ones == 5) begin
                tick(1'b0, 1'b1);
                st_ones = 0;
            end
        end else begin
            st_ones = 0;
        end
    endtask

    task automatic frame_open();
        g_crc = 16'hFFFF;
        send_flag();
    endtask

    task automatic frame_byte(input logic [7:0] v);
        for (int i = 0; i < 8; i++) begin
            g_crc = (g_crc >> 1) ^ ((g_crc[0] ^ v[i]) ? 16'h8408 : 16'h0000);
            send_dbit(v[i]);
        end
    endtask

    task automatic frame_close(input bit corrupt, output logic [15:0] fw);
        fw = ~g_crc ^ {15'd0, corrupt};
        for (int i = 0; i < 16; i++) send_dbit(fw[i]);
        send_flag();
    endtask

    task automatic send_frame(input logic [63:0] d, input int len, input bit corrupt,
                              output logic [15:0] fw);
        frame_open();
        for (int i = 0; i < len; i++) frame_byte(d[8*i +: 8]);
        frame_close(corrupt, fw);
    endtask

    function automatic logic [15:0] rev16(input logic [15:0] x);
        for (int i = 0; i < 16; i++) rev16[15-i] = x[i];
    endfunction

    task automatic expect_frame(input string req, input int mark, input logic [63:0] d,
                                input int len, input bit good);
        check({req, " byte count"}, cap_n - mark, len);
        if (cap_n - mark == len) begin
            for (int i = 0; i < len; i++) begin
                check({req, " R3 data"}, {24'd0, cap_b[mark+i]}, {24'd0, d[8*i +: 8]});
                check({req, " R3 first"}, {31'd0, cap_f[mark+i]}, {31'd0, i == 0});
                check({req, " R3 eop"}, {31'd0, cap_e[mark+i]}, {31'd0, i == len-1});
                if (i == len-1) check({req, " R4 verdict"}, {31'd0, cap_g[mark+i]}, {31'd0, good});
            end
        end
    endtask

    initial begin
        logic [15:0] fw;
        int mark;
        st_ones = 0;
        g_crc = 16'hFFFF;
        repeat (4) @(negedge clk);
        // R1: reset state
        check("R1 reset out_valid", {31'd0, out_valid}, 32'd0);
        check("R1 reset rx_fcs", {16'd0, rx_fcs}, 32'd0);
        rst_n = 1'b1;
        idle(2);

        // R8: enable and first flag bit on the same cycle
        mark = cap_n;
        @(negedge clk); rx_enable = 1'b1; bit_in = 1'b0; bit_en = 1'b1;
        for (int i = 0; i < 6; i++) tick(1'b1, 1'b1);
        tick(1'b0, 1'b1);
        g_crc = 16'hFFFF; st_ones = 0;
        frame_byte(8'h21); frame_byte(8'h43);
        frame_close(1'b0, fw);
        idle(3);
        expect_frame("R8 same-cycle enable", mark, 64'h4321, 2, 1'b1);

        // R1: bits before any flag are ignored
        rx_enable = 1'b0; idle(2); rx_enable = 1'b1;
        mark = cap_n;
        for (int i = 0; i < 40; i++) send_dbit(i[0]);
        idle(2);
        check("R1 no output before flag", cap_n - mark, 0);

        // Vector table walk: R2, R3, R4, R5, R7
        for (int v = 0; v < NV; v++) begin
            mark = cap_n;
            send_frame(V_DATA[v], V_LEN[v], V_BAD[v], fw);
            idle(3);
            expect_frame($sformatf("vec%0d R2/R5", v), mark, V_DATA[v], V_LEN[v],
                         !V_BAD[v] && V_LEN[v] >= 2);
            check($sformatf("vec%0d R7 rx_fcs", v), {16'd0, rx_fcs}, {16'd0, rev16(fw)});
        end

        // R10: idle and back-to-back flags
        mark = cap_n;
        for (int i = 0; i < 6; i++) send_flag();
        idle(3);
        check("R10 idle flags", cap_n - mark, 0);

        // R6: abort inside a packet
        mark = cap_n;
        frame_open();
        frame_byte(8'h11); frame_byte(8'h22); frame_byte(8'h33);
        frame_byte(8'h44); frame_byte(8'h55); frame_byte(8'h66);
        for (int i = 0; i < 8; i++) tick(1'b1, 1'b1);
        idle(3);
        check("R6 abort gives bytes", {31'd0, (cap_n - mark) >= 1}, 32'd1);
        if (cap_n > mark) begin
            check("R6 first byte", {24'd0, cap_b[mark]}, 32'h11);
            check("R6 last eop", {31'd0, cap_e[cap_n-1]}, 32'd1);
            check("R6 last bad", {31'd0, cap_g[cap_n-1]}, 32'd0);
        end
        mark = cap_n;
        send_frame(64'h0A09, 2, 1'b0, fw);
        idle(3);
        expect_frame("R6 recovery", mark, 64'h0A09, 2, 1'b1);

        // R1: enable rising partway through a packet
        rx_enable = 1'b0;
        mark = cap_n;
        frame_open(); frame_byte(8'h31); frame_byte(8'h32);
        rx_enable = 1'b1;
        frame_byte(8'h33); frame_byte(8'h34);
        frame_close(1'b0, fw);
        idle(3);
        check("R1 mid-packet enable ignored", cap_n - mark, 0);
        mark = cap_n;
        send_frame(64'h5A4B, 2, 1'b0, fw);
        idle(3);
        expect_frame("R1 next packet", mark, 64'h5A4B, 2, 1'b1);

        // R9: disable late in a packet lets it finish
        mark = cap_n;
        frame_open();
        frame_byte(8'hA1); frame_byte(8'hB2); frame_byte(8'hC3);
        frame_byte(8'hD4); frame_byte(8'hE5);
        rx_enable = 1'b0;
        frame_byte(8'h96);
        frame_close(1'b0, fw);
        idle(3);
        expect_frame("R9 drain", mark, 64'h96E5D4C3B2A1, 6, 1'b1);
        mark = cap_n;
        send_frame(64'h0201, 2, 1'b0, fw);
        idle(3);
        check("R9 stopped after drain", cap_n - mark, 0);

        // R9: disable early in a packet drops it
        rx_enable = 1'b1;
        mark = cap_n;
        frame_open(); frame_byte(8'h71); frame_byte(8'h72);
        rx_enable = 1'b0;
        frame_byte(8'h73); frame_byte(8'h74);
        frame_close(1'b0, fw);
        idle(3);
        check("R9 early disable drops", cap_n - mark, 0);
        rx_enable = 1'b1;
        mark = cap_n;
        send_frame(64'h6655, 2, 1'b0, fw);
        idle(3);
        expect_frame("R9 re-enable", mark, 64'h6655, 2, 1'b1);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule